// File: doc/BRIEF.md
# Paged Program-Memory Loader

This block lets a host fill an on-chip microcontroller's program RAM through a narrow register port. The host sees a control register, an expected-checksum register, a running-sum register and a window that is one page wide. A 3-bit page field in the control register picks which slice of program RAM the window lands on. As a result, eight pages of `PAGE_BYTES` each can be loaded through a window that never grows.

The host opens a download session by setting the enable bit. It then streams whole 32-bit words into the window and uses byte-lane writes for a trailing remainder, switching pages as it goes. Finally it writes the expected sum and closes the session. On close, the block compares the sum of everything it accepted against the expected value and raises a report bit on a match. The host may set the ready bit only after that report has been seen. The microcontroller reads program RAM through its own word-addressed port with one cycle of latency. It can also flag, through a pulse input, that it is executing from RAM. The host clears that flag by writing a zero to the low control byte.

Top module: `fw_dl_window`

## Requirements
- R1: After reset the control register (byte offset 0x0) and the sum register (byte offset 0x8) read as zero.
- R2: While download is enabled, a write to the window (host address bit 11 set) stores each enabled byte lane into program RAM word `page*PAGE_WORDS + addr[OFF_W+1:2]`. The microcontroller port returns that word one cycle after it presents the address.
- R3: While download is disabled (control bit 0 clear), window writes change neither program RAM nor the running sum.
- R4: The page is control bits 18:16. Window address bits between the page offset and bit 11, and bits 1:0, are ignored, so the offset wraps within one page.
- R5: The running sum (readable at 0x8) is the 32-bit sum of the data of accepted window writes, with disabled lanes taken as zero. It is cleared in the cycle that enable goes from 0 to 1.
- R6: Control bit 4 (sum report) is set when a control write turns enable from 1 to 0 while the sum equals the expected register (0x4). It is cleared by such a close with a mismatch, and by enable rising.
- R7: Control bit 5 (ready) is set by a control write with bit 5 set only while the sum report is already set. It reads back as set. It is cleared by enable rising, by a mismatching close, or by a control write with bit 5 clear.
- R8: Control bit 7 (running from RAM) is set by a one-cycle pulse on `mcu_run_i`. A write to control byte 0 with bit 7 clear clears it.
- R9: Control bit 19 is written by the host through byte lane 2. It is forced to 0 whenever enable rises, even if the same write sets it.
- R10: A window write with only some byte enables set leaves the other bytes of the RAM word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | 12 | Host byte address |
| be_i | input | 4 | Host byte enables |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, combinational |
| mcu_addr_i | input | RAM_AW | Microcontroller program word address |
| mcu_rdata_o | output | 32 | Program word, registered |
| mcu_run_i | input | 1 | Pulse: microcontroller now runs from RAM |
| dl_en_o | output | 1 | Download enable |
| sum_ok_o | output | 1 | Sum report |
| ready_o | output | 1 | Ready flag |

## Verification
The bench goes after the handshake order. It asks for ready before the report exists, after a good close and after a bad close. A design that lets ready through early or keeps a stale report across a new session shows a wrong control readback. Window writes land on random pages with junk in the ignored address bits and with partial byte enables. A design that does not wrap offsets, or that clobbers unselected lanes, returns wrong words on the microcontroller port. Writes while closed, and a write that both opens the session and sets bit 19, catch blocks that accept data without enable or that let the host override the clear-on-open.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;
  localparam int PAGE_SEL_W = 3;
  localparam int N_PAGES    = 1 << PAGE_SEL_W;
  // control bit positions
  localparam int C_EN   = 0;
  localparam int C_OK   = 4;
  localparam int C_RDY  = 5;
  localparam int C_RUN  = 7;
  localparam int C_PAGE = 16;
  localparam int C_AUX  = 19;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_EXP  = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fwdl_ctrl.sv
module fwdl_ctrl
  import fwdl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [3:0]            be_i,
  input  logic [31:0]           wdata_i,
  input  logic                  mcu_run_i,
  input  logic                  sum_match_i,
  output logic                  en_rise_o,
  output logic                  en_o,
  output logic                  ok_o,
  output logic                  rdy_o,
  output logic [PAGE_SEL_W-1:0] page_o,
  output logic [31:0]           ctrl_o
);
  logic en_q, ok_q, rdy_q, run_q, aux_q;
  logic [PAGE_SEL_W-1:0] page_q;
  logic en_wr, rise, fall, ok_d, rdy_d, run_d, aux_d;
  logic unused_ctrl;

  assign unused_ctrl = ^{be_i[3], be_i[1], wdata_i[31:20], wdata_i[15:8], wdata_i[6], wdata_i[4:1]};

  assign en_wr = wr_i & be_i[0];
  assign rise  = en_wr &  wdata_i[C_EN] & ~en_q;
  assign fall  = en_wr & ~wdata_i[C_EN] &  en_q;

  always_comb begin
    ok_d = ok_q;
    if (rise)      ok_d = 1'b0;
    else if (fall) ok_d = sum_match_i;
    // ready only follows an already visible report
    if (rise)       rdy_d = 1'b0;
    else if (en_wr) rdy_d = wdata_i[C_RDY] & ok_q & ok_d;
    else            rdy_d = rdy_q & ok_d;
    run_d = run_q;
    if (mcu_run_i)                      run_d = 1'b1;
    else if (en_wr && !wdata_i[C_RUN])  run_d = 1'b0;
    aux_d = aux_q;
    if (rise)                    aux_d = 1'b0;
    else if (wr_i && be_i[2])    aux_d = wdata_i[C_AUX];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ok_q   <= 1'b0;
      rdy_q  <= 1'b0;
      run_q  <= 1'b0;
      aux_q  <= 1'b0;
      page_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata_i[C_EN];
      ok_q  <= ok_d;
      rdy_q <= rdy_d;
      run_q <= run_d;
      aux_q <= aux_d;
      if (wr_i && be_i[2]) page_q <= wdata_i[C_PAGE +: PAGE_SEL_W];
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[C_EN]  = en_q;
    ctrl_o[C_OK]  = ok_q;
    ctrl_o[C_RDY] = rdy_q;
    ctrl_o[C_RUN] = run_q;
    ctrl_o[C_PAGE +: PAGE_SEL_W] = page_q;
    ctrl_o[C_AUX] = aux_q;
  end

  assign en_rise_o = rise;
  assign en_o      = en_q;
  assign ok_o      = ok_q;
  assign rdy_o     = rdy_q;
  assign page_o    = page_q;

  // R6
  ok_on_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_q) |-> ($past(en_q) && !en_q));
  // R7
  rdy_needs_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q |-> ok_q);
  // R8
  run_from_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(mcu_run_i));
  // R9
  aux_clr_on_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> !aux_q);
endmodule

// File: rtl/fwdl_csum.sv
module fwdl_csum #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          exp_we_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] exp_o,
  output logic          match_o
);
  logic [DW-1:0] sum_q, exp_q, masked;

  for (genvar l = 0; l < DW/8; l++) begin : g_mask
    assign masked[l*8 +: 8] = be_i[l] ? wdata_i[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      exp_q <= '0;
    end else begin
      if (clr_i)      sum_q <= '0;
      else if (add_i) sum_q <= sum_q + masked;
      if (exp_we_i)   exp_q <= masked | (exp_q & ~{DW{1'b0}} & ~expand_be(be_i));
    end
  end

  function automatic logic [DW-1:0] expand_be(input logic [DW/8-1:0] b);
    for (int i = 0; i < DW/8; i++) expand_be[i*8 +: 8] = {8{b[i]}};
  endfunction

  assign sum_o   = sum_q;
  assign exp_o   = exp_q;
  assign match_o = (sum_q == exp_q);

  // R5
  sum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_i && !clr_i) |=> $stable(sum_q));
endmodule

// File: rtl/fwdl_ram.sv
module fwdl_ram #(
  parameter int WORDS = 512,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem[waddr_i] <= wdata_i[l*8 +: 8];
      rd_q <= mem[raddr_i];
    end
    assign rdata_o[l*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/fw_dl_window.sv
module fw_dl_window
  import fwdl_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int HADDR_W    = 12,
  parameter int WIN_BIT    = 11,
  localparam int PAGE_WORDS = PAGE_BYTES / 4,
  localparam int OFF_W      = $clog2(PAGE_WORDS),
  localparam int RAM_WORDS  = N_PAGES * PAGE_WORDS,
  localparam int RAM_AW     = OFF_W + PAGE_SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [HADDR_W-1:0] addr_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [RAM_AW-1:0]  mcu_addr_i,
  output logic [31:0]        mcu_rdata_o,
  input  logic               mcu_run_i,
  output logic               dl_en_o,
  output logic               sum_ok_o,
  output logic               ready_o
);
  reg_sel_e sel;
  logic win_hit, win_acc, ctrl_wr, exp_wr, en_rise, en, match;
  logic [PAGE_SEL_W-1:0] page;
  logic [31:0] ctrl_val, sum_val, exp_val;
  logic [RAM_AW-1:0] waddr;
  logic unused_addr;

  assign unused_addr = ^addr_i;

  always_comb begin
    sel = SEL_NONE;
    if (!addr_i[WIN_BIT]) begin
      case (addr_i[3:2])
        2'd0:    sel = SEL_CTRL;
        2'd1:    sel = SEL_EXP;
        2'd2:    sel = SEL_SUM;
        default: sel = SEL_NONE;
      endcase
    end
  end

  assign win_hit = req_i & we_i & addr_i[WIN_BIT];
  assign win_acc = win_hit & en;
  assign ctrl_wr = req_i & we_i & (sel == SEL_CTRL);
  assign exp_wr  = req_i & we_i & (sel == SEL_EXP);
  assign waddr   = {page, addr_i[OFF_W+1:2]};

  fwdl_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(ctrl_wr), .be_i, .wdata_i, .mcu_run_i,
    .sum_match_i(match),
    .en_rise_o(en_rise), .en_o(en), .ok_o(sum_ok_o), .rdy_o(ready_o),
    .page_o(page), .ctrl_o(ctrl_val)
  );

  fwdl_csum #(.DW(32)) u_csum (
    .clk_i, .rst_ni,
    .clr_i(en_rise), .add_i(win_acc), .be_i, .wdata_i,
    .exp_we_i(exp_wr),
    .sum_o(sum_val), .exp_o(exp_val), .match_o(match)
  );

  fwdl_ram #(.WORDS(RAM_WORDS), .AW(RAM_AW)) u_ram (
    .clk_i,
    .we_i(win_acc), .waddr_i(waddr), .be_i, .wdata_i,
    .raddr_i(mcu_addr_i), .rdata_o(mcu_rdata_o)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: rdata_o = ctrl_val;
      SEL_EXP:  rdata_o = exp_val;
      SEL_SUM:  rdata_o = sum_val;
      default:  rdata_o = '0;
    endcase
  end

  assign dl_en_o = en;
endmodule

// File: tb/fw_dl_window_test.sv
module fw_dl_window_test;
  localparam int PW = 64;
  localparam int NW = 8 * PW;
  localparam int AW = 9;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, mcu_run = 0;
  logic [11:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0, rdata, mcu_rdata;
  logic [AW-1:0] mcu_addr = '0;
  logic dl_en, sum_ok, ready;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model [NW];
  bit touched [NW];
  logic [31:0] msum;
  logic [2:0] cur_page;

  always #10 clk = ~clk;

  fw_dl_window uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .mcu_addr_i(mcu_addr),
    .mcu_rdata_o(mcu_rdata), .mcu_run_i(mcu_run), .dl_en_o(dl_en),
    .sum_ok_o(sum_ok), .ready_o(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic mrd(input int w, output logic [31:0] d);
    @(negedge clk);
    mcu_addr = AW'(w);
    @(negedge clk);
    d = mcu_rdata;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [3:0] b,
                                        input logic [31:0] d);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (b[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mask(input logic [3:0] b, input logic [31:0] d);
    return merge(32'h0, b, d);
  endfunction

  // model-tracked window write while enabled
  task automatic win_wr(input int pg, input int off, input logic [3:0] b, input logic [31:0] d,
                        input logic [2:0] junk);
    int w = pg * PW + off;
    wr({1'b1, junk, 6'(off), 2'b11}, b, d);
    model[w] = merge(touched[w] ? model[w] : 32'h0, b, d);
    touched[w] = 1;
    msum += mask(b, d);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NW; i++) touched[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(12'h000, v); chk("R1 ctrl", v, 32'h0);
    rd(12'h008, v); chk("R1 sum", v, 32'h0);

    // open with aux set in same write: aux forced clear
    wr(12'h000, 4'b0101, 32'h0008_0001);
    rd(12'h000, v); chk("R9 aux clr on open", v, 32'h0000_0001);
    wr(12'h000, 4'b0100, 32'h0008_0000);
    rd(12'h000, v); chk("R9 aux write", v, 32'h0008_0001);
    msum = 0;

    // word 0 of page 0 with full word, then tail byte lanes on page 7
    wr(12'h000, 4'b0100, 32'h0);
    win_wr(0, 0, 4'hF, 32'h1234_5678, 3'b000);
    wr(12'h000, 4'b0100, 32'h0007_0000);
    win_wr(7, PW - 1, 4'hF, 32'hA5A5_A5A5, 3'b101);
    win_wr(7, PW - 1, 4'b0010, 32'h0000_3C00, 3'b000);
    win_wr(7, PW - 1, 4'b1000, 32'h7700_0000, 3'b011);

    for (int k = 0; k < 60; k++) begin
      int pg = $urandom_range(0, 7);
      int off = $urandom_range(0, PW - 1);
      logic [3:0] b = (k % 4 == 3) ? 4'($urandom_range(1, 15)) : 4'hF;
      wr(12'h000, 4'b0100, {13'h0, 3'(pg), 16'h0});
      win_wr(pg, off, b, $urandom, 3'($urandom_range(0, 7)));
    end
    rd(12'h008, v); chk("R5 running sum", v, msum);

    // ready asked before report exists
    wr(12'h000, 4'b0001, 32'h21);
    rd(12'h000, v); chk("R7 no early ready", {26'h0, v[5:0]}, 32'h1);

    wr(12'h004, 4'hF, msum);
    wr(12'h000, 4'b0001, 32'h0);
    rd(12'h000, v); chk("R6 report on match", {31'h0, v[4]}, 1);
    wr(12'h000, 4'b0001, 32'h20);
    rd(12'h000, v); chk("R7 ready after report", {30'h0, v[5:4]}, 2'b11);

    // closed write ignored
    wr(12'h000, 4'b0100, 32'h0);
    wr(12'h800, 4'hF, 32'hDEAD_BEEF);
    mrd(0, v); chk("R3 closed write RAM", v, model[0]);
    rd(12'h008, v); chk("R3 closed write sum", v, msum);

    begin
      int bad = 0;
      for (int w = 0; w < NW; w++) if (touched[w]) begin
        mrd(w, v);
        n_run++;
        if (v !== model[w]) begin
          n_fail++; bad++;
          $display("FAIL R2/R4/R10 word %0d: got %h expected %h", w, v, model[w]);
        end
      end
      chk("R2 words checked", 32'(bad), 0);
    end
    mrd(7 * PW + PW - 1, v); chk("R10 partial lanes", v, model[7 * PW + PW - 1]);

    // new session: report and ready clear, sum resets
    wr(12'h000, 4'b0001, 32'h1);
    rd(12'h000, v); chk("R6 R7 clear on open", {26'h0, v[5:0]}, 32'h1);
    rd(12'h008, v); chk("R5 sum clear on open", v, 0);
    msum = 0;
    win_wr(0, 3, 4'hF, 32'h0000_0010, 3'b000);
    wr(12'h004, 4'hF, msum + 1);
    wr(12'h000, 4'b0001, 32'h0);
    rd(12'h000, v); chk("R6 mismatch no report", {31'h0, v[4]}, 0);
    wr(12'h000, 4'b0001, 32'h20);
    rd(12'h000, v); chk("R7 no ready on mismatch", {31'h0, v[5]}, 0);
    mrd(3, v); chk("R2 second session", v, 32'h10);

    // run flag
    @(negedge clk); mcu_run = 1;
    @(negedge clk); mcu_run = 0;
    rd(12'h000, v); chk("R8 run set", {31'h0, v[7]}, 1);
    wr(12'h000, 4'b0001, 32'h0);
    rd(12'h000, v); chk("R8 run clear", {31'h0, v[7]}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule